// File: doc/BRIEF.md
# Notification Mix Arming Sequencer

This block decides when a short PCM notification may be summed into a DSD playback stream that is already running. A host raises a mix request. The sequencer first powers up the PCM serial port and waits until that port reports its clocks are running. It then raises a prepare flag and counts a settling interval in system ticks. With the default of 1600 ticks of 1 µs, that interval is 1.6 ms. Only after the interval does it raise the mix flag. While the mix flag is high, it also drives a fixed attenuation for each of the two paths, so that the sum cannot clip.

When the host drops the request, the block takes the prepare and mix flags low on the same edge. It holds the port for a single teardown cycle and then returns to idle, where the PCM port is powered down again. If the port clocks fail during the settling interval, the interval starts again from zero. If the request is withdrawn before mixing starts, the block returns to idle and the mix flag is never raised. The block does not add samples and does not touch the DSD modulator. It only produces the control levels that gate those functions.

Top module: `notif_mix_seq`

## Requirements
- R1: After reset, `mix_state_o` is 0 (idle), and `port_en`, `prep_flag`, `mix_flag`, `pcm_atten_db` and `dsd_atten_db` are all 0.
- R2: In idle, a sampled `mix_req` makes the next cycle show `mix_state_o` = 1 (port-up) with `port_en` high. While `port_clk_ok` stays low, `prep_flag` stays low, and ticks have no effect on later timing.
- R3: In port-up, `port_clk_ok` sampled high makes the next cycle show `prep_flag` high with `mix_state_o` = 2 (settling). `prep_flag` never rises unless `port_clk_ok` was high on the preceding edge.
- R4: In settling, a tick is counted on each edge where `tick` and `port_clk_ok` are both high. `mix_flag` rises exactly one cycle after the edge that counts the WAIT_TICKS-th tick, with `mix_state_o` = 3 (mixing). It is never high earlier.
- R5: Any edge in settling with `port_clk_ok` low resets the tick count to zero, and `prep_flag` stays high.
- R6: When `mix_req` is sampled low in mixing, `prep_flag` and `mix_flag` fall on the same edge. That cycle shows `mix_state_o` = 4 (teardown) with `port_en` still high, and the cycle after shows idle with `port_en` low.
- R7: When `mix_req` is sampled low in settling, the block passes through teardown into idle, and `mix_flag` stays low throughout.
- R8: When `mix_req` is sampled low in port-up, the next cycle is idle with `port_en` low.
- R9: While in mixing, `pcm_atten_db` equals max(PCM_ATTEN_DB, 6) and `dsd_atten_db` equals max(DSD_ATTEN_DB, 6). In every other state, both are 0.
- R10: Whenever `mix_flag` is high, `prep_flag` and `port_en` are also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time base strobe, one cycle wide |
| mix_req | input | 1 | Host level request for notification mixing |
| port_clk_ok | input | 1 | PCM serial port clocks are running at the notification rate |
| port_en | output | 1 | Power/enable for the PCM serial port |
| prep_flag | output | 1 | Mix preparation indication to the datapath |
| mix_flag | output | 1 | Summation enable to the datapath |
| pcm_atten_db | output | ATTEN_W | PCM path attenuation in dB while mixing |
| dsd_atten_db | output | ATTEN_W | DSD path attenuation in dB while mixing |
| mix_state_o | output | 3 | Current sequencer state code |

## Verification
The assertions assume the following about the inputs:
- `mix_req` and `port_clk_ok` are synchronous levels that can change on any cycle.
- `tick` is a one-cycle strobe.
- The PCM port clocks are in step with the DSD clock, so a single `port_clk_ok` level is meaningful.

The bench changes every input only on the falling clock edge. It sweeps tick spacing from 1 to 3 cycles and every point of the settling count at which the clocks can fail. It also withdraws the request in each state, so every state transition is exercised without glitching any input.

// File: rtl/nms_pkg.sv
package nms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PORT_UP   = 3'd1,
        ST_PREP_WAIT = 3'd2,
        ST_MIXING    = 3'd3,
        ST_TEARDOWN  = 3'd4
    } mix_state_e;

    localparam int MIN_ATTEN_DB = 6;
    localparam int NUM_PATHS    = 2;
    localparam int PATH_PCM     = 0;
    localparam int PATH_DSD     = 1;

    typedef struct packed {
        logic port_en;
        logic prep;
        logic mix;
    } mix_ctl_t;

    function automatic int atten_floor(input int req_db);
        return (req_db < MIN_ATTEN_DB) ? MIN_ATTEN_DB : req_db;
    endfunction

    function automatic mix_ctl_t ctl_for_state(input mix_state_e s);
        mix_ctl_t c;
        c = '0;
        case (s)
            ST_PORT_UP:   c.port_en = 1'b1;
            ST_PREP_WAIT: begin c.port_en = 1'b1; c.prep = 1'b1; end
            ST_MIXING:    begin c.port_en = 1'b1; c.prep = 1'b1; c.mix = 1'b1; end
            ST_TEARDOWN:  c.port_en = 1'b1;
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nms_settle_timer.sv
module nms_settle_timer #(
    parameter int WAIT_TICKS = 1600
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clk_ok,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(WAIT_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(WAIT_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || !clk_ok) begin
            cnt <= '0;
        end else if (tick && (cnt != LIMIT)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign done = (cnt == LIMIT);
endmodule

// File: rtl/nms_ctrl_fsm.sv
module nms_ctrl_fsm
    import nms_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       clk_ok,
    input  logic       settle_done,
    output mix_state_e state
);
    mix_state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:      if (req) nxt = ST_PORT_UP;
            ST_PORT_UP: begin
                if (!req)        nxt = ST_IDLE;
                else if (clk_ok) nxt = ST_PREP_WAIT;
            end
            ST_PREP_WAIT: begin
                if (!req)                       nxt = ST_TEARDOWN;
                else if (settle_done && clk_ok) nxt = ST_MIXING;
            end
            ST_MIXING:    if (!req) nxt = ST_TEARDOWN;
            ST_TEARDOWN:  nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/nms_out_decode.sv
module nms_out_decode
    import nms_pkg::*;
#(
    parameter int ATTEN_W      = 6,
    parameter int PCM_ATTEN_DB = 6,
    parameter int DSD_ATTEN_DB = 12
) (
    input  mix_state_e                        state,
    output mix_ctl_t                          ctl,
    output logic [NUM_PATHS-1:0][ATTEN_W-1:0] atten
);
    assign ctl = ctl_for_state(state);

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        localparam int REQ_DB = (g == PATH_PCM) ? PCM_ATTEN_DB : DSD_ATTEN_DB;
        localparam logic [ATTEN_W-1:0] ATT = ATTEN_W'(atten_floor(REQ_DB));
        assign atten[g] = ctl.mix ? ATT : '0;
    end
endmodule

// File: rtl/notif_mix_seq.sv
module notif_mix_seq
    import nms_pkg::*;
#(
    parameter int WAIT_TICKS   = 1600,
    parameter int ATTEN_W      = 6,
    parameter int PCM_ATTEN_DB = 6,
    parameter int DSD_ATTEN_DB = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               mix_req,
    input  logic               port_clk_ok,
    output logic               port_en,
    output logic               prep_flag,
    output logic               mix_flag,
    output logic [ATTEN_W-1:0] pcm_atten_db,
    output logic [ATTEN_W-1:0] dsd_atten_db,
    output logic [2:0]         mix_state_o
);
    mix_state_e                        state;
    logic                              settle_done;
    mix_ctl_t                          ctl;
    logic [NUM_PATHS-1:0][ATTEN_W-1:0] atten;

    nms_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (mix_req),
        .clk_ok      (port_clk_ok),
        .settle_done (settle_done),
        .state       (state)
    );

    nms_settle_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (state == ST_PREP_WAIT),
        .clk_ok (port_clk_ok),
        .tick   (tick),
        .done   (settle_done)
    );

    nms_out_decode #(
        .ATTEN_W      (ATTEN_W),
        .PCM_ATTEN_DB (PCM_ATTEN_DB),
        .DSD_ATTEN_DB (DSD_ATTEN_DB)
    ) u_dec (
        .state (state),
        .ctl   (ctl),
        .atten (atten)
    );

    assign port_en      = ctl.port_en;
    assign prep_flag    = ctl.prep;
    assign mix_flag     = ctl.mix;
    assign pcm_atten_db = atten[PATH_PCM];
    assign dsd_atten_db = atten[PATH_DSD];
    assign mix_state_o  = state;
endmodule

// File: rtl/nms_checker.sv
module nms_checker #(
    parameter int WAIT_TICKS = 1600,
    parameter int ATTEN_W    = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               mix_req,
    input logic               port_clk_ok,
    input logic               port_en,
    input logic               prep_flag,
    input logic               mix_flag,
    input logic [ATTEN_W-1:0] pcm_atten_db,
    input logic [ATTEN_W-1:0] dsd_atten_db,
    input logic [2:0]         mix_state_o
);
    localparam int SW = $clog2(WAIT_TICKS + 2);
    localparam logic [SW-1:0] CAP = SW'(WAIT_TICKS + 1);

    logic [SW-1:0] since_prep;
    always_ff @(posedge clk) begin
        if (rst || !prep_flag)   since_prep <= '0;
        else if (since_prep != CAP) since_prep <= since_prep + SW'(1);
    end

    assert_prep_needs_clocks_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(prep_flag) |-> ($past(port_clk_ok) && $past(mix_req)));

    assert_mix_after_settle_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mix_flag) |-> (since_prep >= SW'(WAIT_TICKS)));

    assert_mix_from_wait_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mix_flag) |-> ($past(mix_state_o) == 3'd2));

    assert_flags_drop_together_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(mix_flag) |-> $fell(prep_flag));

    assert_teardown_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (mix_state_o == 3'd4) |=> (mix_state_o == 3'd0));

    assert_atten_in_mix_R9: assert property (@(posedge clk) disable iff (rst)
        mix_flag |-> ((pcm_atten_db >= ATTEN_W'(6)) && (dsd_atten_db >= ATTEN_W'(6))));

    assert_atten_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !mix_flag |-> ((pcm_atten_db == '0) && (dsd_atten_db == '0)));

    assert_mix_implies_prep_R10: assert property (@(posedge clk) disable iff (rst)
        mix_flag |-> (prep_flag && port_en));

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
        mix_state_o <= 3'd4);
endmodule

bind notif_mix_seq nms_checker #(.WAIT_TICKS(WAIT_TICKS), .ATTEN_W(ATTEN_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mix_req      (mix_req),
    .port_clk_ok  (port_clk_ok),
    .port_en      (port_en),
    .prep_flag    (prep_flag),
    .mix_flag     (mix_flag),
    .pcm_atten_db (pcm_atten_db),
    .dsd_atten_db (dsd_atten_db),
    .mix_state_o  (mix_state_o)
);

// File: tb/tb_notif_mix_seq.sv
module tb_notif_mix_seq;
    localparam int W    = 5;
    localparam int AW   = 6;
    localparam int PCMA = 3;
    localparam int DSDA = 9;
    localparam int EXP_PCM = (PCMA < 6) ? 6 : PCMA;
    localparam int EXP_DSD = (DSDA < 6) ? 6 : DSDA;

    logic clk = 1'b0;
    logic rst, tick, mix_req, port_clk_ok;
    logic port_en, prep_flag, mix_flag;
    logic [AW-1:0] pcm_atten_db, dsd_atten_db;
    logic [2:0] mix_state_o;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    notif_mix_seq #(
        .WAIT_TICKS(W), .ATTEN_W(AW), .PCM_ATTEN_DB(PCMA), .DSD_ATTEN_DB(DSDA)
    ) dut (
        .clk(clk), .rst(rst), .tick(tick), .mix_req(mix_req), .port_clk_ok(port_clk_ok),
        .port_en(port_en), .prep_flag(prep_flag), .mix_flag(mix_flag),
        .pcm_atten_db(pcm_atten_db), .dsd_atten_db(dsd_atten_db), .mix_state_o(mix_state_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R10 observed every cycle
    always @(negedge clk) begin
        cycles++;
        if (!rst && mix_flag) chk("R10 prep&port_en while mix", int'(prep_flag && port_en), 1);
    end

    initial begin
        while (!finished) begin
            @(negedge clk);
            if (cycles > 150000) begin
                errs++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=done", cycles);
                $display("Result: errors=%0d of %0d checks", errs, checks);
                $finish;
            end
        end
    end

    task automatic give_tick(input int p);
        tick = 1'b1; step(1); tick = 1'b0;
        if (p > 1) step(p - 1);
    endtask

    // reach settling state from idle
    task automatic to_prep();
        mix_req = 1'b1; port_clk_ok = 1'b0;
        step(1);
        chk("R2 state port-up", mix_state_o, 1);
        chk("R2 port_en", port_en, 1);
        tick = 1'b1; step(2 * W); tick = 1'b0;
        chk("R2 prep low without clocks", prep_flag, 0);
        port_clk_ok = 1'b1;
        step(1);
        chk("R3 prep raised", prep_flag, 1);
        chk("R3 state settling", mix_state_o, 2);
    endtask

    task automatic run_mix(input int p, input int restart_at);
        to_prep();
        if (restart_at >= 0) begin
            for (int i = 0; i < restart_at; i++) give_tick(p);
            port_clk_ok = 1'b0; step(1); port_clk_ok = 1'b1;
            chk("R5 prep held during clock loss", prep_flag, 1);
        end
        for (int i = 0; i < W - 1; i++) give_tick(p);
        step(2);
        chk("R4 no mix before last tick", mix_flag, 0);
        tick = 1'b1; step(1); tick = 1'b0;
        chk("R4 no mix on count edge", mix_flag, 0);
        step(1);
        chk("R4 mix raised", mix_flag, 1);
        chk("R4 state mixing", mix_state_o, 3);
        chk("R9 pcm atten", pcm_atten_db, EXP_PCM);
        chk("R9 dsd atten", dsd_atten_db, EXP_DSD);
        step(3);
        chk("R6 prep before stop", prep_flag, 1);
        mix_req = 1'b0;
        step(1);
        chk("R6 mix dropped", mix_flag, 0);
        chk("R6 prep dropped same cycle", prep_flag, 0);
        chk("R6 teardown state", mix_state_o, 4);
        chk("R6 port_en in teardown", port_en, 1);
        chk("R9 atten zero after mix", pcm_atten_db + dsd_atten_db, 0);
        step(1);
        chk("R6 idle", mix_state_o, 0);
        chk("R6 port off", port_en, 0);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; mix_req = 1'b0; port_clk_ok = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 state idle", mix_state_o, 0);
        chk("R1 flags", {port_en, prep_flag, mix_flag}, 0);
        chk("R1 atten", pcm_atten_db + dsd_atten_db, 0);
        chk("R9 atten zero in idle", pcm_atten_db, 0);

        for (int p = 1; p <= 3; p++)
            for (int r = -1; r < W; r++) run_mix(p, r);

        // R8: withdraw in port-up
        mix_req = 1'b1; port_clk_ok = 1'b0;
        step(1);
        chk("R8 port-up", mix_state_o, 1);
        mix_req = 1'b0;
        step(1);
        chk("R8 idle", mix_state_o, 0);
        chk("R8 port off", port_en, 0);

        // R7: withdraw during settling at each point of the count
        for (int k = 0; k < W; k++) begin
            to_prep();
            for (int i = 0; i < k; i++) give_tick(1);
            mix_req = 1'b0;
            step(1);
            chk("R7 teardown", mix_state_o, 4);
            chk("R7 no mix", mix_flag, 0);
            chk("R7 prep dropped", prep_flag, 0);
            tick = 1'b1;
            for (int i = 0; i < W + 2; i++) begin
                step(1);
                chk("R7 mix stays low", mix_flag, 0);
            end
            tick = 1'b0;
            chk("R7 idle", mix_state_o, 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule